// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter with Prescaler

This peripheral keeps a 16-bit up-count that software reaches as a low byte and a high byte over a small register bus. The count advances from one of three sources: a one-cycle instruction tick from the processor (timer mode), an external clock pin that is resynchronized to the system clock, or the same pin taken without resynchronization. A power-of-two prescaler sits between the chosen source and the count. An optional gate input can hold counting.

When the count wraps from 0xFFFF to 0x0000, an overflow flag is set. An interrupt request goes out only while that flag and three enable bits are all set. Software clears the flag by writing it. A write to either count byte also resets the hidden prescale counter, so that a reload starts a full division period. In external-clock mode, rising edges are ignored after enable until a falling edge has been seen. As a result, a pin that is already low or high at enable never produces a false first count.

Register addresses on `bus_addr`: 0 count low byte, 1 count high byte, 2 control, 3 flag, 4 interrupt enables. Reads are combinational. Writes take effect at the clock edge.

Top module: `gated_timer16`

## Requirements
- R1: After reset, the count bytes (addresses 0 and 1), the control register (address 2), the flag register (address 3) and `irq` all read 0.
- R2: With control bit 0 (on) set, bit 1 clear (internal source) and prescale field 00, each cycle with `inst_tick` high adds 1 to the count read at addresses 0/1.
- R3: Control bits 5:4 pick the divide ratio: 00 divides by 1, 01 by 2, 10 by 4, 11 by 8. The count advances on every Nth source event.
- R4: A write to address 0 or 1 resets the prescale counter to zero, so a full N further events are needed for the next increment.
- R5: While the on bit is 0, source events leave the count unchanged.
- R6: A wrap from 0xFFFF to 0x0000 sets bit 0 of the flag register (address 3).
- R7: Writing 0 to flag bit 0 clears it. If that write falls in the same cycle as a wrap, the flag stays set.
- R8: `irq` is high exactly when flag bit 0 and enable-register bits 0, 6 and 7 (address 4) are all 1.
- R9: With control bit 6 (gate enable) set, no counting happens while `gate_in` is low. With bit 6 clear, `gate_in` has no effect.
- R10: With control bit 1 set and bit 2 clear, rising edges of `ext_clk` are counted after a two-flop resynchronizer. The count changes on the third clock edge after the pin rises.
- R11: With control bits 1 and 2 set, `ext_clk` edges are counted without resynchronization. The count changes on the first clock edge after the pin rises.
- R12: In external mode, once the on bit is set, rising edges are ignored until a falling edge of `ext_clk` has been detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| inst_tick | input | 1 | Instruction-cycle tick, timer-mode source |
| ext_clk | input | 1 | External clock pin |
| gate_in | input | 1 | Count gate, counting allowed while high |
| irq | output | 1 | Qualified overflow interrupt request |

## Verification
The hardest situation to reach is a flag-clearing write that lands in exactly the cycle in which the count wraps. The bench loads 0xFFFF with the prescaler at divide-by-1 and then drives the clearing write and a tick in the same cycle. The other hard point is the difference between the two external paths, which shows up only as latency. With the gate armed by a prior falling edge, the bench raises the pin and reads the count one clock later and three clocks later, in each mode.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int PSEL_W = 2;
  localparam int PCNT_W = (1 << PSEL_W) - 1;

  localparam logic [2:0] ADR_CNT_LO = 3'd0;
  localparam logic [2:0] ADR_CNT_HI = 3'd1;
  localparam logic [2:0] ADR_CTRL   = 3'd2;
  localparam logic [2:0] ADR_FLAG   = 3'd3;
  localparam logic [2:0] ADR_IEN    = 3'd4;

  localparam int CB_ON    = 0;
  localparam int CB_EXT   = 1;
  localparam int CB_ASYNC = 2;
  localparam int CB_PS_LO = 4;
  localparam int CB_GATE  = 6;

  localparam int IB_TMR  = 0;
  localparam int IB_PERI = 6;
  localparam int IB_GLOB = 7;

  // Last prescale count value before an increment: divide ratio minus one.
  function automatic logic [PCNT_W-1:0] presc_limit(input logic [PSEL_W-1:0] sel);
    logic [PCNT_W:0] ratio;
    ratio = (PCNT_W+1)'(1) << sel;
    return PCNT_W'(ratio - (PCNT_W+1)'(1));
  endfunction

  function automatic logic irq_qual(input logic flag, input logic [7:0] ien);
    return flag & ien[IB_TMR] & ien[IB_PERI] & ien[IB_GLOB];
  endfunction
endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic async_mode,
  input  logic run,
  output logic rise_ok
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic src, prev_q, rise_raw, fall_raw, armed_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end
  endgenerate

  assign src      = async_mode ? pin : sync_q[SYNC_STAGES-1];
  assign rise_raw = src & ~prev_q;
  assign fall_raw = ~src & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q <= src;
      if (!run)          armed_q <= 1'b0;
      else if (fall_raw) armed_q <= 1'b1;
    end
  end

  assign rise_ok = rise_raw & armed_q & run;

  AST_ARM_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(fall_raw)); // R12
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_evt,
  input  logic              clr,
  input  logic [PSEL_W-1:0] sel,
  output logic              fire
);
  logic [PCNT_W-1:0] pre_q;
  logic              at_limit;

  assign at_limit = (pre_q >= presc_limit(sel));
  assign fire     = src_evt & ~clr & at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (clr)     pre_q <= '0;
    else if (src_evt) pre_q <= at_limit ? '0 : pre_q + PCNT_W'(1);
  end

  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0)); // R4
endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
  import tmr16_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              inst_tick,
  input  logic              ext_clk,
  input  logic              gate_in,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] ctrl_q, ien_q;
  logic              ovf_flag;

  logic lo_wr, hi_wr, cnt_wr, ctrl_wr, flag_wr, ien_wr;
  logic ctrl_on, ext_sel, async_sel, gate_en, gate_ok;
  logic ext_rise, src_evt, inc_evt, wrap_evt;

  assign lo_wr   = bus_wr && (bus_addr == ADR_CNT_LO);
  assign hi_wr   = bus_wr && (bus_addr == ADR_CNT_HI);
  assign ctrl_wr = bus_wr && (bus_addr == ADR_CTRL);
  assign flag_wr = bus_wr && (bus_addr == ADR_FLAG);
  assign ien_wr  = bus_wr && (bus_addr == ADR_IEN);
  assign cnt_wr  = lo_wr | hi_wr;

  assign ctrl_on   = ctrl_q[CB_ON];
  assign ext_sel   = ctrl_q[CB_EXT];
  assign async_sel = ctrl_q[CB_ASYNC];
  assign gate_en   = ctrl_q[CB_GATE];
  assign gate_ok   = ~gate_en | gate_in;

  tmr16_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin        (ext_clk),
    .async_mode (async_sel),
    .run        (ctrl_on),
    .rise_ok    (ext_rise)
  );

  assign src_evt = ctrl_on & gate_ok & (ext_sel ? ext_rise : inst_tick);

  tmr16_prescale i_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_evt (src_evt),
    .clr     (cnt_wr),
    .sel     (ctrl_q[CB_PS_LO +: PSEL_W]),
    .fire    (inc_evt)
  );

  assign wrap_evt = inc_evt & ~cnt_wr & (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      if (lo_wr) cnt_q[DATA_W-1:0]     <= bus_wdata;
      if (hi_wr) cnt_q[CNT_W-1:DATA_W] <= bus_wdata;
    end else if (inc_evt) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ien_q    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata;
      if (ien_wr)  ien_q  <= bus_wdata;
      if (wrap_evt)     ovf_flag <= 1'b1;
      else if (flag_wr) ovf_flag <= bus_wdata[0];
    end
  end

  assign irq = irq_qual(ovf_flag, ien_q);

  always_comb begin
    unique case (bus_addr)
      ADR_CNT_LO: bus_rdata = cnt_q[DATA_W-1:0];
      ADR_CNT_HI: bus_rdata = cnt_q[CNT_W-1:DATA_W];
      ADR_CTRL:   bus_rdata = ctrl_q;
      ADR_FLAG:   bus_rdata = {{(DATA_W-1){1'b0}}, ovf_flag};
      ADR_IEN:    bus_rdata = ien_q;
      default:    bus_rdata = '0;
    endcase
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt && !cnt_wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_on && !cnt_wr) |=> $stable(cnt_q)); // R5
  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !gate_in && !cnt_wr) |=> $stable(cnt_q)); // R9
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (ovf_flag && cnt_q == '0)); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flag && ien_q[IB_GLOB])); // R8
endmodule

// File: tb/test_gated_timer16.sv
module test_gated_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       inst_tick = 1'b0;
  logic       ext_clk = 1'b0;
  logic       gate_in = 1'b0;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gated_timer16 i_gated_timer16 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inst_tick(inst_tick),
    .ext_clk(ext_clk), .gate_in(gate_in), .irq(irq)
  );

  // {control value, tick count, expected count low byte}
  localparam logic [23:0] VEC [6] = '{
    {8'h01, 8'd5,  8'd5},
    {8'h11, 8'd5,  8'd2},
    {8'h21, 8'd9,  8'd2},
    {8'h31, 8'd17, 8'd2},
    {8'h31, 8'd7,  8'd0},
    {8'h21, 8'd4,  8'd1}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); inst_tick = 1'b1;
      @(negedge clk); inst_tick = 1'b0;
    end
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_clk = 1'b1;
    repeat (4) @(negedge clk);
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_count(input logic [7:0] hi, input logic [7:0] lo);
    wr(3'd0, lo);
    wr(3'd1, hi);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(3'd0, d); chk("R1 cnt lo", d, 0);
    rd(3'd1, d); chk("R1 cnt hi", d, 0);
    rd(3'd2, d); chk("R1 ctrl", d, 0);
    rd(3'd3, d); chk("R1 flag", d, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 prescale table
    foreach (VEC[i]) begin
      wr(3'd2, VEC[i][23:16]);
      set_count(8'h00, 8'h00);
      ticks(int'(VEC[i][15:8]));
      rd(3'd0, d);
      chk(i == 0 ? "R2 timer step" : "R3 prescale", d, VEC[i][7:0]);
    end

    // R4 count write clears prescaler
    wr(3'd2, 8'h31);
    set_count(8'h00, 8'h00);
    ticks(5);
    wr(3'd0, 8'h10);
    ticks(7);
    rd(3'd0, d); chk("R4 pre cleared (7 ticks)", d, 8'h10);
    ticks(1);
    rd(3'd0, d); chk("R4 pre cleared (8 ticks)", d, 8'h11);

    // R5 off holds count
    wr(3'd2, 8'h00);
    ticks(4);
    rd(3'd0, d); chk("R5 hold when off", d, 8'h11);

    // R6 wrap sets flag
    wr(3'd2, 8'h01);
    set_count(8'hFF, 8'hFF);
    ticks(1);
    rd(3'd0, d); chk("R6 wrap lo", d, 0);
    rd(3'd1, d); chk("R6 wrap hi", d, 0);
    rd(3'd3, d); chk("R6 flag set", d, 1);
    chk("R8 irq no enables", irq, 0);

    // R8 qualification
    wr(3'd4, 8'h41); #1; chk("R8 irq missing global", irq, 0);
    wr(3'd4, 8'h81); #1; chk("R8 irq missing peripheral", irq, 0);
    wr(3'd4, 8'hC0); #1; chk("R8 irq missing timer", irq, 0);
    wr(3'd4, 8'hC1); #1; chk("R8 irq all set", irq, 1);

    // R7 clear and collision
    wr(3'd3, 8'h00);
    rd(3'd3, d); chk("R7 flag cleared", d, 0);
    chk("R8 irq after clear", irq, 0);
    set_count(8'hFF, 8'hFF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 8'h00; inst_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; inst_tick = 1'b0;
    rd(3'd3, d); chk("R7 wrap beats clear", d, 1);
    rd(3'd0, d); chk("R7 wrap count", d, 0);
    wr(3'd3, 8'h00);

    // R9 gate
    wr(3'd2, 8'h41);
    set_count(8'h00, 8'h00);
    gate_in = 1'b0;
    ticks(3);
    rd(3'd0, d); chk("R9 gate low blocks", d, 0);
    gate_in = 1'b1;
    ticks(3);
    rd(3'd0, d); chk("R9 gate high counts", d, 3);
    wr(3'd2, 8'h01);
    gate_in = 1'b0;
    ticks(2);
    rd(3'd0, d); chk("R9 gate ignored when disabled", d, 5);

    // R10 / R12 synchronous external
    wr(3'd2, 8'h00);
    ext_clk = 1'b0;
    wr(3'd2, 8'h03);
    set_count(8'h00, 8'h00);
    pulse_ext();
    rd(3'd0, d); chk("R12 first rise ignored (sync)", d, 0);
    pulse_ext(); pulse_ext();
    rd(3'd0, d); chk("R10 sync pulses", d, 2);
    ticks(3);
    rd(3'd0, d); chk("R10 tick ignored in ext mode", d, 2);
    @(negedge clk); ext_clk = 1'b1;
    @(negedge clk);
    rd(3'd0, d); chk("R10 sync not yet after 1 clk", d, 2);
    repeat (2) @(negedge clk);
    rd(3'd0, d); chk("R10 sync after 3 clks", d, 3);
    ext_clk = 1'b0;
    repeat (4) @(negedge clk);

    // R11 / R12 asynchronous external
    wr(3'd2, 8'h00);
    wr(3'd2, 8'h07);
    set_count(8'h00, 8'h00);
    pulse_ext();
    rd(3'd0, d); chk("R12 first rise ignored (async)", d, 0);
    pulse_ext(); pulse_ext();
    rd(3'd0, d); chk("R11 async pulses", d, 2);
    @(negedge clk); ext_clk = 1'b1;
    @(negedge clk);
    rd(3'd0, d); chk("R11 async after 1 clk", d, 3);
    ext_clk = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule